// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative address-translation cache for a 32-bit virtual address space with 4 KB pages. Each slot holds a 20-bit virtual page number, a 24-bit physical frame number, an 8-bit address-space tag, a global flag, a dirty flag and three cache-attribute bits. Every slot is compared in the same cycle. On a match the block returns a 36-bit physical address, which is the frame number followed by the untranslated 12-bit page offset. If nothing matches, it raises a miss so that privileged software can refill the missing translation.

Software installs translations through a single write port. The target slot is either an explicit index or the slot currently named by a free-running pseudo-random generator. That slot number is shown on an output, so software can know which slot it is replacing. The current address-space tag is held in a register that software writes. A flush input drops every translation at once, which is used on a context switch when tags are not in use.

Lookup results are combinational in the lookup cycle. Writes, flushes and tag loads take effect at the next rising clock edge.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, `xlatPaddr` equals the matched slot's 24-bit frame number concatenated above bits [11:0] of `lookupVaddr`. Bits [31:12] of `lookupVaddr` are the page number that is compared.
- R2: After reset no slot is valid, so every lookup misses until a slot is written with `wrValid` = 1.
- R3: A valid slot matches when its page number equals `lookupVaddr[31:12]` and either its tag equals `curAsid` or its global flag is 1.
- R4: On a match, `xlatDirty`, `xlatCattr` and `xlatIndex` give the matched slot's dirty flag, cache attributes and slot number.
- R5: When `lookupValid` = 1 and no slot matches, `xlatMiss` = 1, `xlatHit` = 0, and `xlatPaddr`, `xlatDirty`, `xlatCattr` and `xlatIndex` are all zero. Exactly one of hit, miss and fault is high for each lookup.
- R6: A matching lookup with `lookupIsWrite` = 1 whose slot has its dirty flag at 0 raises `xlatModFault` instead of `xlatHit`, and `xlatPaddr` is zero. The same page read with `lookupIsWrite` = 0 hits.
- R7: A write with `wrUseRandom` = 0 replaces slot `wrIndex` with the supplied fields. Writing `wrValid` = 0 removes that slot's translation.
- R8: A write with `wrUseRandom` = 1 lands in the slot that `victimIdx` shows in the cycle of the write.
- R9: `flushAll` clears every slot's valid flag at the next edge. A write in the same cycle as a flush is discarded.
- R10: `curAsid` resets to 0. It takes `asidWrData` at the edge where `asidWrEn` = 1 and holds its value otherwise.
- R11: When several valid slots match, the lowest-numbered slot supplies every result.
- R12: When `lookupValid` = 0, `xlatHit`, `xlatMiss`, `xlatModFault`, `xlatPaddr`, `xlatDirty`, `xlatCattr` and `xlatIndex` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A translation request is present |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupIsWrite | input | 1 | The request is a store |
| xlatHit | output | 1 | Translation found and permitted |
| xlatMiss | output | 1 | No slot matches |
| xlatModFault | output | 1 | Store to a page whose dirty flag is clear |
| xlatPaddr | output | 36 | Physical address on a hit |
| xlatDirty | output | 1 | Dirty flag of the matched slot |
| xlatCattr | output | 3 | Cache attributes of the matched slot |
| xlatIndex | output | 4 | Number of the matched slot |
| wrEn | input | 1 | Install a translation |
| wrUseRandom | input | 1 | Use the random victim instead of wrIndex |
| wrIndex | input | 4 | Explicit target slot |
| wrValid | input | 1 | Valid flag to store |
| wrVpn | input | 20 | Page number to store |
| wrAsid | input | 8 | Address-space tag to store |
| wrGlobal | input | 1 | Global flag to store |
| wrPfn | input | 24 | Frame number to store |
| wrDirty | input | 1 | Dirty flag to store |
| wrCattr | input | 3 | Cache attributes to store |
| asidWrEn | input | 1 | Load the current address-space tag |
| asidWrData | input | 8 | New current tag |
| curAsid | output | 8 | Current address-space tag |
| flushAll | input | 1 | Invalidate every slot |
| victimIdx | output | 4 | Slot a random write would use this cycle |

## Verification
The checker watches several rules on every cycle:
- hit, miss and fault never rise together;
- all outputs stay quiet while no request is present;
- the page offset passes straight through on a hit;
- misses and faults carry no address;
- nothing hits in the cycle after a flush;
- the tag register loads and holds exactly when it is told to.

Other behaviours need stored state that the checker does not model, so only the bench's scenarios can show them:
- which slot wins when two slots match;
- whether tag matching and the global flag follow the current tag;
- that a random write lands on the announced slot;
- that a write beside a flush is dropped.

The bench fills all sixteen slots and then sweeps four tag values, with both loads and stores, against its own model of the table.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = 24;
  localparam int PA_W    = PFN_W + OFF_W;
  localparam int ASID_W  = 8;
  localparam int CATTR_W = 3;

  typedef struct packed {
    logic               valid;
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
    logic               global;
    logic [PFN_W-1:0]   pfn;
    logic               dirty;
    logic [CATTR_W-1:0] cattr;
  } tlbEntry_t;

  typedef struct packed {
    logic flush;
    logic write;
    logic asidLoad;
  } tlbStrobes_t;
endpackage

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrUseRandom,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic              asidWrEn,
  input  logic [ASID_W-1:0] asidWrData,
  input  logic              flushAll,
  output tlbStrobes_t       strobes,
  output logic [IDX_W-1:0]  wrSlot,
  output logic [ASID_W-1:0] asidReg,
  output logic [IDX_W-1:0]  randIdx
);
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;

  always_comb begin
    lfsrNext = {1'b0, lfsrQ[LFSR_W-1:1]};
    if (lfsrQ[0]) lfsrNext = lfsrNext ^ LFSR_TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= {{(LFSR_W-1){1'b0}}, 1'b1};
    else       lfsrQ <= lfsrNext;
  end

  assign randIdx = lfsrQ[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)         asidReg <= '0;
    else if (asidWrEn) asidReg <= asidWrData;
  end

  always_comb begin
    strobes.flush    = flushAll;
    strobes.write    = wrEn & ~flushAll;
    strobes.asidLoad = asidWrEn;
    wrSlot           = wrUseRandom ? randIdx : wrIndex;
  end
endmodule

// File: rtl/asid_tlb_dpath.sv
module asid_tlb_dpath
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strobes,
  input  logic [IDX_W-1:0]   wrSlot,
  input  tlbEntry_t          wrEntry,
  input  logic [ASID_W-1:0]  asidReg,
  input  logic               lookupValid,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic               lookupIsWrite,
  output logic               xlatHit,
  output logic               xlatMiss,
  output logic               xlatModFault,
  output logic [PA_W-1:0]    xlatPaddr,
  output logic               xlatDirty,
  output logic [CATTR_W-1:0] xlatCattr,
  output logic [IDX_W-1:0]   xlatIndex
);
  tlbEntry_t                entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]   matchVec;
  logic [VPN_W-1:0]         reqVpn;
  logic [OFF_W-1:0]         reqOff;

  assign reqVpn = lookupVaddr[VA_W-1:OFF_W];
  assign reqOff = lookupVaddr[OFF_W-1:0];

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        entries[gi] <= '0;
      else if (strobes.flush)
        entries[gi].valid <= 1'b0;
      else if (strobes.write && wrSlot == IDX_W'(gi))
        entries[gi] <= wrEntry;
    end

    assign matchVec[gi] = entries[gi].valid &&
                          entries[gi].vpn == reqVpn &&
                          (entries[gi].global || entries[gi].asid == asidReg);
  end

  logic             anyMatch;
  logic [IDX_W-1:0] selIdx;
  tlbEntry_t        selEntry;

  always_comb begin
    anyMatch = 1'b0;
    selIdx   = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (matchVec[k]) begin
        anyMatch = 1'b1;
        selIdx   = IDX_W'(k);
      end
    end
    selEntry = entries[selIdx];
  end

  always_comb begin
    xlatHit      = 1'b0;
    xlatMiss     = 1'b0;
    xlatModFault = 1'b0;
    xlatPaddr    = '0;
    xlatDirty    = 1'b0;
    xlatCattr    = '0;
    xlatIndex    = '0;
    if (lookupValid) begin
      if (!anyMatch) begin
        xlatMiss = 1'b1;
      end else begin
        xlatDirty = selEntry.dirty;
        xlatCattr = selEntry.cattr;
        xlatIndex = selIdx;
        if (lookupIsWrite && !selEntry.dirty) begin
          xlatModFault = 1'b1;
        end else begin
          xlatHit   = 1'b1;
          xlatPaddr = {selEntry.pfn, reqOff};
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LFSR_W      = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [31:0]        lookupVaddr,
  input  logic               lookupIsWrite,
  output logic               xlatHit,
  output logic               xlatMiss,
  output logic               xlatModFault,
  output logic [35:0]        xlatPaddr,
  output logic               xlatDirty,
  output logic [2:0]         xlatCattr,
  output logic [IDX_W-1:0]   xlatIndex,
  input  logic               wrEn,
  input  logic               wrUseRandom,
  input  logic [IDX_W-1:0]   wrIndex,
  input  logic               wrValid,
  input  logic [19:0]        wrVpn,
  input  logic [7:0]         wrAsid,
  input  logic               wrGlobal,
  input  logic [23:0]        wrPfn,
  input  logic               wrDirty,
  input  logic [2:0]         wrCattr,
  input  logic               asidWrEn,
  input  logic [7:0]         asidWrData,
  output logic [7:0]         curAsid,
  input  logic               flushAll,
  output logic [IDX_W-1:0]   victimIdx
);
  tlbStrobes_t      strobes;
  logic [IDX_W-1:0] wrSlot;
  tlbEntry_t        wrEntry;

  assign wrEntry = '{valid: wrValid, vpn: wrVpn, asid: wrAsid, global: wrGlobal,
                     pfn: wrPfn, dirty: wrDirty, cattr: wrCattr};

  asid_tlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .LFSR_W(LFSR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrUseRandom(wrUseRandom),
    .wrIndex(wrIndex), .asidWrEn(asidWrEn), .asidWrData(asidWrData),
    .flushAll(flushAll), .strobes(strobes), .wrSlot(wrSlot),
    .asidReg(curAsid), .randIdx(victimIdx)
  );

  asid_tlb_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrSlot(wrSlot),
    .wrEntry(wrEntry), .asidReg(curAsid), .lookupValid(lookupValid),
    .lookupVaddr(lookupVaddr), .lookupIsWrite(lookupIsWrite),
    .xlatHit(xlatHit), .xlatMiss(xlatMiss), .xlatModFault(xlatModFault),
    .xlatPaddr(xlatPaddr), .xlatDirty(xlatDirty), .xlatCattr(xlatCattr),
    .xlatIndex(xlatIndex)
  );
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [31:0]      lookupVaddr,
  input logic             xlatHit,
  input logic             xlatMiss,
  input logic             xlatModFault,
  input logic [35:0]      xlatPaddr,
  input logic             xlatDirty,
  input logic [2:0]       xlatCattr,
  input logic [IDX_W-1:0] xlatIndex,
  input logic             asidWrEn,
  input logic [7:0]       asidWrData,
  input logic [7:0]       curAsid,
  input logic             flushAll
);
  assert_outcome_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $countones({xlatHit, xlatMiss, xlatModFault}) == 1);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!xlatHit && !xlatMiss && !xlatModFault && xlatPaddr == '0 &&
                      !xlatDirty && xlatCattr == '0 && xlatIndex == '0));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    xlatHit |-> xlatPaddr[11:0] == lookupVaddr[11:0]);

  assert_miss_no_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    xlatMiss |-> (xlatPaddr == '0 && xlatIndex == '0 && !xlatDirty));

  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    xlatModFault |-> (xlatPaddr == '0 && !xlatDirty));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !(xlatHit || xlatModFault));

  assert_asid_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    asidWrEn |=> curAsid == $past(asidWrData));

  assert_asid_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !asidWrEn |=> $stable(curAsid));
endmodule

bind asid_tlb asid_tlb_chk #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
  .xlatHit(xlatHit), .xlatMiss(xlatMiss), .xlatModFault(xlatModFault),
  .xlatPaddr(xlatPaddr), .xlatDirty(xlatDirty), .xlatCattr(xlatCattr),
  .xlatIndex(xlatIndex), .asidWrEn(asidWrEn), .asidWrData(asidWrData),
  .curAsid(curAsid), .flushAll(flushAll)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic        lookupIsWrite = 1'b0;
  logic        xlatHit, xlatMiss, xlatModFault, xlatDirty;
  logic [35:0] xlatPaddr;
  logic [2:0]  xlatCattr;
  logic [3:0]  xlatIndex;
  logic        wrEn = 1'b0, wrUseRandom = 1'b0, wrValid = 1'b0, wrGlobal = 1'b0, wrDirty = 1'b0;
  logic [3:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic [23:0] wrPfn = '0;
  logic [2:0]  wrCattr = '0;
  logic        asidWrEn = 1'b0;
  logic [7:0]  asidWrData = '0;
  logic [7:0]  curAsid;
  logic        flushAll = 1'b0;
  logic [3:0]  victimIdx;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  // bench model of the table
  bit         mValid [N];
  bit [19:0]  mVpn   [N];
  bit [7:0]   mAsid  [N];
  bit         mGlob  [N];
  bit [23:0]  mPfn   [N];
  bit         mDirty [N];
  bit [2:0]   mCattr [N];
  bit [7:0]   mCur = '0;

  always #4 clk = ~clk;

  asid_tlb dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge; edge that follows commits it
  task automatic writeSlot(input bit useRnd, input int idx, input bit v, input bit [19:0] vpn,
                           input bit [7:0] asid, input bit g, input bit [23:0] pfn,
                           input bit d, input bit [2:0] ca, output int slot);
    @(negedge clk);
    wrEn = 1'b1; wrUseRandom = useRnd; wrIndex = idx[3:0]; wrValid = v; wrVpn = vpn;
    wrAsid = asid; wrGlobal = g; wrPfn = pfn; wrDirty = d; wrCattr = ca;
    #1;
    slot = useRnd ? int'(victimIdx) : idx;
    @(negedge clk);
    wrEn = 1'b0; wrUseRandom = 1'b0;
    mValid[slot] = v; mVpn[slot] = vpn; mAsid[slot] = asid; mGlob[slot] = g;
    mPfn[slot] = pfn; mDirty[slot] = d; mCattr[slot] = ca;
  endtask

  task automatic setAsid(input bit [7:0] a);
    @(negedge clk);
    asidWrEn = 1'b1; asidWrData = a;
    @(negedge clk);
    asidWrEn = 1'b0;
    mCur = a;
  endtask

  task automatic lookup(input string tag, input bit [31:0] va, input bit isWr);
    bit found = 1'b0;
    int sel = 0;
    bit eHit, eMiss, eFault, eD;
    bit [35:0] ePa;
    bit [2:0] eCa;
    bit [3:0] eIdx;
    for (int i = 0; i < N; i++)
      if (!found && mValid[i] && mVpn[i] == va[31:12] && (mGlob[i] || mAsid[i] == mCur)) begin
        found = 1'b1; sel = i;
      end
    eMiss  = !found;
    eFault = found && isWr && !mDirty[sel];
    eHit   = found && !eFault;
    ePa    = eHit ? {mPfn[sel], va[11:0]} : 36'h0;
    eD     = found ? mDirty[sel] : 1'b0;
    eCa    = found ? mCattr[sel] : 3'h0;
    eIdx   = found ? sel[3:0] : 4'h0;
    @(negedge clk);
    lookupValid = 1'b1; lookupVaddr = va; lookupIsWrite = isWr;
    #1;
    check(tag, {15'h0, xlatHit, xlatMiss, xlatModFault, xlatPaddr, xlatDirty, xlatCattr, xlatIndex},
               {15'h0, eHit, eMiss, eFault, ePa, eD, eCa, eIdx});
    @(negedge clk);
    lookupValid = 1'b0; lookupIsWrite = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int s;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset value, R12 idle outputs
    check("R10 reset asid", {56'h0, curAsid}, 64'h0);
    check("R12 idle", {24'h0, xlatHit, xlatMiss, xlatModFault, xlatPaddr, xlatDirty},
                      {24'h0, 1'b0, 1'b0, 1'b0, 36'h0, 1'b0});
    // R2: empty after reset
    lookup("R2 empty", 32'h0000_5123, 1'b0);
    lookup("R2 empty", 32'h0016_A000, 1'b1);

    // R7 fill every slot explicitly
    for (int i = 0; i < N; i++)
      writeSlot(1'b0, i, 1'b1, 20'(i * 32'h111 + 5), 8'(i % 4), (i == 7),
                24'(32'hABC00 + i * 3), i[0], 3'(i % 8), s);

    // R1 R3 R4 R6: sweep tags, loads and stores
    for (int a = 0; a < 4; a++) begin
      setAsid(8'(a));
      check("R10 asid load", {56'h0, curAsid}, 64'(a));
      for (int i = 0; i < N; i++)
        for (int w = 0; w < 2; w++)
          lookup("R3 R4 R6 R1 sweep", {20'(i * 32'h111 + 5), 12'((i * 37 + a * 5) & 32'hFFF)}, w[0]);
    end

    // R5 unknown page
    lookup("R5 unknown page", 32'hFEDC_B123, 1'b0);

    // R7 remove slot 3 (tag 3 active)
    writeSlot(1'b0, 3, 1'b0, 20'(3 * 32'h111 + 5), 8'd3, 1'b0, 24'h0, 1'b1, 3'h0, s);
    lookup("R7 invalidated", {20'(3 * 32'h111 + 5), 12'h040}, 1'b0);

    // R11 duplicate: slot 12 duplicates slot 2 (tag 2)
    setAsid(8'd2);
    writeSlot(1'b0, 12, 1'b1, 20'(2 * 32'h111 + 5), 8'd2, 1'b0, 24'h777777, 1'b1, 3'h5, s);
    lookup("R11 lowest wins", {20'(2 * 32'h111 + 5), 12'h321}, 1'b0);
    writeSlot(1'b0, 2, 1'b0, 20'h0, 8'd0, 1'b0, 24'h0, 1'b0, 3'h0, s);
    lookup("R11 next wins", {20'(2 * 32'h111 + 5), 12'h321}, 1'b1);

    // R8 random victim, several times at different phases
    for (int r = 0; r < 4; r++) begin
      repeat (r + 1) @(negedge clk);
      writeSlot(1'b1, 0, 1'b1, 20'(32'hF0000 + r), 8'h99, 1'b1, 24'(32'h100 + r), 1'b1, 3'(r), s);
      lookup("R8 random slot", {20'(32'hF0000 + r), 12'h008}, 1'b0);
    end

    // R9 flush with a simultaneous write
    @(negedge clk);
    flushAll = 1'b1; wrEn = 1'b1; wrUseRandom = 1'b0; wrIndex = 4'd5; wrValid = 1'b1;
    wrVpn = 20'h12345; wrAsid = 8'd2; wrGlobal = 1'b1; wrPfn = 24'h1; wrDirty = 1'b1; wrCattr = 3'h1;
    @(negedge clk);
    flushAll = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    lookup("R9 dropped write", 32'h1234_5000, 1'b0);
    lookup("R9 flushed", {20'(4 * 32'h111 + 5), 12'h0}, 1'b0);
    lookup("R9 flushed global", {20'h F0000, 12'h0}, 1'b0);

    // R12 idle with a matching address present
    writeSlot(1'b0, 9, 1'b1, 20'h00ABC, 8'd2, 1'b0, 24'h55AA55, 1'b1, 3'h7, s);
    @(negedge clk);
    lookupValid = 1'b0; lookupVaddr = 32'h00AB_C010;
    #1;
    check("R12 idle with match", {24'h0, xlatHit, xlatMiss, xlatModFault, xlatPaddr, xlatDirty},
                                 {24'h0, 1'b0, 1'b0, 1'b0, 36'h0, 1'b0});
    lookup("R1 after reload", 32'h00AB_C010, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule